// File: doc/BRIEF.md
# Per-Lane Block-Number Branch Controller

This unit steers a 16-lane SIMD engine through arbitrary control flow, including irreducible graphs, while all lanes share one program flow. The unit has no reconvergence stack. Each lane holds a 16-bit block number that names the basic block where the lane must run next. A lane is live in the current block when its stored number is at most that block's ID. The unit receives a stream of control operations: block entry (join), forward branch, backward branch and return. From each operation it produces the live-lane mask, a jump decision with its target, and an end-of-thread pulse.

The compiler supplies every block ID and every join target as an operand. A forward branch whose lanes must still visit the next sequential block falls through. A join whose block has no live lane makes the unit jump to the supplied target. All returns are compiled as jumps to one shared final block, and that block's single return operation raises the end-of-thread pulse.

Top module: `lane_flow_ctl`

## Requirements
- R1: While reset is active, and in the cycle after reset is released, activeMask, jumpTake and endThread are all zero.
- R2: When start is high at a rising edge, every lane's block number is loaded with startId and activeMask becomes all ones after that edge. Start takes priority over an operation presented in the same cycle: that operation is ignored and jumpTarget keeps its value.
- R3: A join (opKind 2'b00) sets bit i of activeMask when lane i's block number is less than or equal to blockId. The comparison is an unsigned 16-bit compare.
- R4: A join raises jumpTake when no lane meets that condition, and does not raise it otherwise. jumpTarget is loaded with targetId on every join, forward branch and backward branch. It holds its value otherwise.
- R5: On a branch, each live lane whose laneCond bit is 1 stores targetId, and each live lane whose bit is 0 stores blockId, which is the fall-through block. Lanes that are not live keep their block number.
- R6: A backward branch (opKind 2'b10) raises jumpTake exactly when some live lane has its laneCond bit set. Condition bits of lanes that are not live are ignored.
- R7: A forward branch (opKind 2'b01) raises jumpTake exactly when every lane's block number, after this branch's update, is strictly greater than blockId.
- R8: A return (opKind 2'b11) raises endThread for one cycle. It does not raise jumpTake and leaves the block numbers unchanged.
- R9: jumpTake and endThread follow the operation of the previous edge only. Both are low after an edge with no operation.
- R10: A branch leaves activeMask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Thread start: load all block numbers |
| startId | input | 16 | ID of the first block |
| opValid | input | 1 | A control operation is presented |
| opKind | input | 2 | 00 join, 01 forward, 10 backward, 11 return |
| blockId | input | 16 | Join: current block; branch: fall-through block |
| targetId | input | 16 | Join target or branch target |
| laneCond | input | 16 | Per-lane branch condition |
| activeMask | output | 16 | Live-lane mask |
| jumpTake | output | 1 | Jump decision for the last operation |
| jumpTarget | output | 16 | Target of the last join or branch |
| endThread | output | 1 | End-of-thread pulse |

## Verification
On a forward branch, the per-lane write of new block numbers and the all-lane decision happen in the same cycle. The decision must see the numbers just written. The bench provokes this in two ways. In one case, live lanes with a false condition land exactly on the fall-through block, and the bench expects no jump. In the other, every live lane moves past the fall-through block, and the bench expects a jump. Start and a join presented together form a second collision, and the bench judges it by mask, jump and target after the edge.

// File: rtl/flow_pkg.sv
package flow_pkg;

  typedef enum logic [1:0] {
    OP_JOIN = 2'b00,
    OP_FWD  = 2'b01,
    OP_BWD  = 2'b10,
    OP_RET  = 2'b11
  } op_e;

  typedef struct packed {
    logic loadAll;
    logic doJoin;
    logic doBranch;
  } dp_strobe_t;

endpackage

// File: rtl/flow_datapath.sv
module flow_datapath #(
  parameter int LANES = 16,
  parameter int IPW   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  flow_pkg::dp_strobe_t  strb,
  input  logic [IPW-1:0]        startId,
  input  logic [IPW-1:0]        blockId,
  input  logic [IPW-1:0]        targetId,
  input  logic [LANES-1:0]      laneCond,
  output logic [LANES-1:0]      activeMask,
  output logic [LANES-1:0]      joinMask,
  output logic                  anyCond,
  output logic                  allBeyond
);

  logic [IPW-1:0]   ipReg  [LANES];
  logic [IPW-1:0]   nextIp [LANES];
  logic [LANES-1:0] beyond;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      joinMask[i] = (ipReg[i] <= blockId);
      if (activeMask[i]) nextIp[i] = laneCond[i] ? targetId : blockId;
      else               nextIp[i] = ipReg[i];
      beyond[i] = (nextIp[i] > blockId);
    end

    always_ff @(posedge clk) begin
      if (!rst_n)             ipReg[i] <= '0;
      else if (strb.loadAll)  ipReg[i] <= startId;
      else if (strb.doBranch) ipReg[i] <= nextIp[i];
    end
  end

  assign anyCond   = |(activeMask & laneCond);
  assign allBeyond = &beyond;

  always_ff @(posedge clk) begin
    if (!rst_n)           activeMask <= '0;
    else if (strb.loadAll) activeMask <= '1;
    else if (strb.doJoin)  activeMask <= joinMask;
  end

endmodule

// File: rtl/flow_control.sv
module flow_control #(
  parameter int LANES = 16,
  parameter int IPW   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  opValid,
  input  logic [1:0]            opKind,
  input  logic [IPW-1:0]        targetId,
  input  logic [LANES-1:0]      joinMask,
  input  logic                  anyCond,
  input  logic                  allBeyond,
  output flow_pkg::dp_strobe_t  strb,
  output logic                  jumpTake,
  output logic [IPW-1:0]        jumpTarget,
  output logic                  endThread
);
  import flow_pkg::*;

  op_e  kind;
  logic live;
  logic takeNext;

  assign kind = op_e'(opKind);
  assign live = opValid && !start;

  always_comb begin
    strb.loadAll  = start;
    strb.doJoin   = live && (kind == OP_JOIN);
    strb.doBranch = live && (kind == OP_FWD || kind == OP_BWD);
    takeNext = 1'b0;
    if (live) begin
      unique case (kind)
        OP_JOIN: takeNext = (joinMask == '0);
        OP_FWD:  takeNext = allBeyond;
        OP_BWD:  takeNext = anyCond;
        default: takeNext = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      jumpTake   <= 1'b0;
      jumpTarget <= '0;
      endThread  <= 1'b0;
    end else begin
      jumpTake  <= takeNext;
      endThread <= live && (kind == OP_RET);
      if (strb.doJoin || strb.doBranch) jumpTarget <= targetId;
    end
  end

endmodule

// File: rtl/lane_flow_ctl.sv
module lane_flow_ctl #(
  parameter int LANES = 16,
  parameter int IPW   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IPW-1:0]   startId,
  input  logic             opValid,
  input  logic [1:0]       opKind,
  input  logic [IPW-1:0]   blockId,
  input  logic [IPW-1:0]   targetId,
  input  logic [LANES-1:0] laneCond,
  output logic [LANES-1:0] activeMask,
  output logic             jumpTake,
  output logic [IPW-1:0]   jumpTarget,
  output logic             endThread
);

  flow_pkg::dp_strobe_t strb;
  logic [LANES-1:0]     joinMask;
  logic                 anyCond;
  logic                 allBeyond;

  flow_datapath #(.LANES(LANES), .IPW(IPW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .startId(startId),
    .blockId(blockId), .targetId(targetId), .laneCond(laneCond),
    .activeMask(activeMask), .joinMask(joinMask),
    .anyCond(anyCond), .allBeyond(allBeyond)
  );

  flow_control #(.LANES(LANES), .IPW(IPW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .opValid(opValid),
    .opKind(opKind), .targetId(targetId), .joinMask(joinMask),
    .anyCond(anyCond), .allBeyond(allBeyond), .strb(strb),
    .jumpTake(jumpTake), .jumpTarget(jumpTarget), .endThread(endThread)
  );

endmodule

// File: rtl/lane_flow_ctl_checker.sv
module lane_flow_ctl_checker #(
  parameter int LANES = 16,
  parameter int IPW   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             opValid,
  input logic [1:0]       opKind,
  input logic [IPW-1:0]   targetId,
  input logic [LANES-1:0] joinMask,
  input logic [LANES-1:0] activeMask,
  input logic             jumpTake,
  input logic [IPW-1:0]   jumpTarget,
  input logic             endThread
);

  logic live;
  assign live = opValid && !start;

  AST_START_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (activeMask == '1)); // R2

  AST_EMPTY_JOIN_JUMPS: assert property (@(posedge clk) disable iff (!rst_n)
    (live && opKind == 2'b00 && joinMask == '0) |=>
      (jumpTake && jumpTarget == $past(targetId))); // R4

  AST_BRANCH_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (live && (opKind == 2'b01 || opKind == 2'b10)) |=> $stable(activeMask)); // R10

  AST_RET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (live && opKind == 2'b11) |=> (endThread && !jumpTake)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!opValid && !start) |=> (!jumpTake && !endThread)); // R9

  AST_JOIN_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (live && opKind == 2'b00) |=> (activeMask == $past(joinMask))); // R3

endmodule

bind lane_flow_ctl lane_flow_ctl_checker #(.LANES(LANES), .IPW(IPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .opValid(opValid),
  .opKind(opKind), .targetId(targetId), .joinMask(joinMask),
  .activeMask(activeMask), .jumpTake(jumpTake), .jumpTarget(jumpTarget),
  .endThread(endThread)
);

// File: tb/sim_lane_flow_ctl.sv
module sim_lane_flow_ctl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] startId;
  logic        opValid;
  logic [1:0]  opKind;
  logic [15:0] blockId;
  logic [15:0] targetId;
  logic [15:0] laneCond;
  logic [15:0] activeMask;
  logic        jumpTake;
  logic [15:0] jumpTarget;
  logic        endThread;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lane_flow_ctl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .startId(startId),
    .opValid(opValid), .opKind(opKind), .blockId(blockId),
    .targetId(targetId), .laneCond(laneCond), .activeMask(activeMask),
    .jumpTake(jumpTake), .jumpTarget(jumpTarget), .endThread(endThread)
  );

  localparam logic [1:0] J = 2'b00, F = 2'b01, B = 2'b10, RT = 2'b11;

  typedef struct packed {
    logic        st;
    logic        vld;
    logic [1:0]  kind;
    logic [15:0] blk;
    logic [15:0] tgt;
    logic [15:0] cond;
    logic [15:0] eMask;
    logic        eJump;
    logic [15:0] eTgt;
    logic        eEot;
  } vec_t;

  // Scenario A: split at 1 and 2, loop on 3, join at 4, early returns, return block 6.
  // Scenario B: block 2 jumps forward past 4 for all lanes; join at 4 then skips to 5.
  localparam int NV = 24;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, J,  16'd1, 16'd0, 16'h0000, 16'hFFFF, 1'b0, 16'd0, 1'b0},
    '{1'b0, 1'b1, J,  16'd1, 16'd2, 16'h0000, 16'hFFFF, 1'b0, 16'd2, 1'b0},
    '{1'b0, 1'b1, F,  16'd2, 16'd4, 16'h000F, 16'hFFFF, 1'b0, 16'd4, 1'b0},
    '{1'b0, 1'b1, J,  16'd2, 16'd4, 16'h0000, 16'hFFF0, 1'b0, 16'd4, 1'b0},
    '{1'b0, 1'b1, F,  16'd3, 16'd5, 16'h00F0, 16'hFFF0, 1'b0, 16'd5, 1'b0},
    '{1'b0, 1'b1, J,  16'd3, 16'd4, 16'h0000, 16'hFF00, 1'b0, 16'd4, 1'b0},
    '{1'b0, 1'b1, B,  16'd4, 16'd3, 16'h0F00, 16'hFF00, 1'b1, 16'd3, 1'b0},
    '{1'b0, 1'b1, J,  16'd3, 16'd4, 16'h0000, 16'h0F00, 1'b0, 16'd4, 1'b0},
    '{1'b0, 1'b1, B,  16'd4, 16'd3, 16'h0000, 16'h0F00, 1'b0, 16'd3, 1'b0},
    '{1'b0, 1'b1, J,  16'd4, 16'd5, 16'h0000, 16'hFF0F, 1'b0, 16'd5, 1'b0},
    '{1'b0, 1'b1, F,  16'd5, 16'd6, 16'h000F, 16'hFF0F, 1'b0, 16'd6, 1'b0},
    '{1'b0, 1'b1, J,  16'd5, 16'd6, 16'h0000, 16'hFFF0, 1'b0, 16'd6, 1'b0},
    '{1'b0, 1'b1, F,  16'd6, 16'd6, 16'h0000, 16'hFFF0, 1'b0, 16'd6, 1'b0},
    '{1'b0, 1'b1, J,  16'd6, 16'd6, 16'h0000, 16'hFFFF, 1'b0, 16'd6, 1'b0},
    '{1'b0, 1'b1, RT, 16'd0, 16'd0, 16'h0000, 16'hFFFF, 1'b0, 16'd6, 1'b1},
    '{1'b0, 1'b0, J,  16'd0, 16'd0, 16'h0000, 16'hFFFF, 1'b0, 16'd6, 1'b0},
    '{1'b1, 1'b0, J,  16'd1, 16'd0, 16'h0000, 16'hFFFF, 1'b0, 16'd6, 1'b0},
    '{1'b0, 1'b1, J,  16'd1, 16'd2, 16'h0000, 16'hFFFF, 1'b0, 16'd2, 1'b0},
    '{1'b0, 1'b1, F,  16'd2, 16'd2, 16'h0000, 16'hFFFF, 1'b0, 16'd2, 1'b0},
    '{1'b0, 1'b1, J,  16'd2, 16'd4, 16'h0000, 16'hFFFF, 1'b0, 16'd4, 1'b0},
    '{1'b0, 1'b1, F,  16'd3, 16'd5, 16'hFFFF, 16'hFFFF, 1'b1, 16'd5, 1'b0},
    '{1'b0, 1'b1, J,  16'd4, 16'd5, 16'h0000, 16'h0000, 1'b1, 16'd5, 1'b0},
    '{1'b0, 1'b1, J,  16'd5, 16'd6, 16'h0000, 16'hFFFF, 1'b0, 16'd6, 1'b0},
    '{1'b0, 1'b0, J,  16'd0, 16'd0, 16'h0000, 16'hFFFF, 1'b0, 16'd6, 1'b0}
  };

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic st, logic [15:0] sid, logic vld, logic [1:0] k,
                      logic [15:0] blk, logic [15:0] tgt, logic [15:0] cnd,
                      logic [15:0] eMask, logic eJump, logic [15:0] eTgt,
                      logic eEot, string ctx);
    @(negedge clk);
    start = st; startId = sid; opValid = vld; opKind = k;
    blockId = blk; targetId = tgt; laneCond = cnd;
    @(posedge clk);
    #1;
    chk({ctx, " R2 R3 R10 activeMask"}, activeMask, eMask);
    chk({ctx, " R4 R6 R7 R9 jumpTake"}, {15'd0, jumpTake}, {15'd0, eJump});
    chk({ctx, " R4 jumpTarget"}, jumpTarget, eTgt);
    chk({ctx, " R8 R9 endThread"}, {15'd0, endThread}, {15'd0, eEot});
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; startId = '0; opValid = 1'b0; opKind = '0;
    blockId = '0; targetId = '0; laneCond = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mask in reset", activeMask, 16'h0000);
    chk("R1 jump in reset", {15'd0, jumpTake}, 16'd0);
    chk("R1 eot in reset", {15'd0, endThread}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 mask after reset", activeMask, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      step(VT[i].st, VT[i].blk, VT[i].vld, VT[i].kind, VT[i].blk, VT[i].tgt,
           VT[i].cond, VT[i].eMask, VT[i].eJump, VT[i].eTgt, VT[i].eEot,
           $sformatf("row%0d", i));
    end

    // R2: start with a concurrent empty join; start wins, target held
    step(1'b1, 16'd7, 1'b1, J, 16'd0, 16'd9, 16'h0, 16'hFFFF, 1'b0, 16'd6, 1'b0, "R2 start+join");
    step(1'b0, 16'd0, 1'b1, J, 16'd7, 16'd8, 16'h0, 16'hFFFF, 1'b0, 16'd8, 1'b0, "R2 ip equals start");
    step(1'b0, 16'd0, 1'b1, J, 16'd6, 16'd9, 16'h0, 16'h0000, 1'b1, 16'd9, 1'b0, "R3 below start");

    // R3: unsigned compare, 0xFFFF is above 0x8000
    step(1'b1, 16'hFFFF, 1'b0, J, 16'd0, 16'd0, 16'h0, 16'hFFFF, 1'b0, 16'd9, 1'b0, "R2 start high id");
    step(1'b0, 16'd0, 1'b1, J, 16'h8000, 16'd1, 16'h0, 16'h0000, 1'b1, 16'd1, 1'b0, "R3 unsigned");

    // R5/R6: conditions of dead lanes ignored, dead lanes keep their number
    step(1'b1, 16'd1, 1'b0, J, 16'd0, 16'd0, 16'h0, 16'hFFFF, 1'b0, 16'd1, 1'b0, "R2 restart");
    step(1'b0, 16'd0, 1'b1, F, 16'd2, 16'd3, 16'h00FF, 16'hFFFF, 1'b0, 16'd3, 1'b0, "R5 split");
    step(1'b0, 16'd0, 1'b1, J, 16'd2, 16'd3, 16'h0, 16'hFF00, 1'b0, 16'd3, 1'b0, "R5 join two");
    step(1'b0, 16'd0, 1'b1, B, 16'd3, 16'd1, 16'h00FF, 16'hFF00, 1'b0, 16'd1, 1'b0, "R6 dead cond");
    step(1'b0, 16'd0, 1'b1, J, 16'd2, 16'd9, 16'h0, 16'h0000, 1'b1, 16'd9, 1'b0, "R5 dead kept");
    step(1'b0, 16'd0, 1'b0, J, 16'd0, 16'd0, 16'h0, 16'h0000, 1'b0, 16'd9, 1'b0, "R9 idle");
    step(1'b0, 16'd0, 1'b1, J, 16'd3, 16'd4, 16'h0, 16'hFFFF, 1'b0, 16'd4, 1'b0, "R5 all at three");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule